// File: doc/BRIEF.md
# Banked System-Control Register Gate

This block is the register window that system software uses to reach the control registers of a small microcontroller interrupt controller. It decodes one request per cycle on a simple bus. Each request carries an address, write data, a write flag, a privilege flag and a security flag. One cycle later the block answers with read data or a bus error. The window holds four registers: a reset/priority-group control register, a configurable fault-status register, a configuration-control register and a software interrupt trigger.

Where a security extension is built in (parameter `HAS_SEC`), the registers are copied per security state. The banking is done bit by bit, so some fields have one copy per state and others are stored once and shared. A second, alias window lets secure code reach the non-secure copies. The block also decides whether a reset request or a software trigger may take effect, based on the security state and privilege of the access that asks for it.

The block drives a one-cycle system reset request, a one-cycle software trigger pulse with its interrupt number, and the priority-group value of each security state.

Top module: `sysctl_bank_gate`

## Requirements
- R1: Every request (req_valid=1) gets rsp_valid=1 in the next cycle, and idle cycles give rsp_valid=0. An erroring response has rsp_rdata=0. After reset all outputs are 0.
- R2: The main window is 0xE000E000–0xE000EFFF. An unprivileged access to the main window gives rsp_err=1. The one exception is a write to the trigger register at offset 0xF00 when bit 1 (user-set-pending) of the configuration register copy of the access's state is 1. Addresses outside both windows give rsp_err=1.
- R3: The alias window is 0xE002E000–0xE002EFFF. With the extension present, a secure access there behaves exactly like a non-secure access to the same offset in the main window.
- R4: A non-secure access to the alias window, or any alias access when the extension is absent, reads 0, changes nothing and gives no error. Without the extension, req_secure is ignored and the main window always uses the non-secure copies. Unused offsets in the main window read 0 and ignore writes.
- R5: The reset/priority control register is at offset 0xD0C. A write takes effect only if wdata[31:16]=0x05FA. Reads return 0xFA05 in bits 31:16. The priority group in bits 10:8 is banked and drives prigroup_s and prigroup_ns.
- R6: Bit 3 (reset-secure-only), bit 13 (faults-to-non-secure) and bit 14 (prioritise-secure) change only on secure writes. Both states can read them. Without the extension they read 0.
- R7: A keyed write with bit 2 set pulses sys_reset_req for one cycle in the next cycle. A non-secure write does not do this while bit 3 is 1, using the value bit 3 held before that write.
- R8: Ones written to bits 0 and 1 of the reset/priority control register have no effect. The rest of the same keyed write still applies.
- R9: The fault-status register is at offset 0xD28. fault_set bits are set in the copy chosen by fault_set_secure. Writing 1 to a bit clears it. Only mask 0x030FBFBB is implemented; all other bits read 0. If a bit is set and cleared in the same cycle, the set wins.
- R10: Fault bits 15:8 are stored once and seen by both states, so a clear from either state removes them for both. The other fault bits are independent per state.
- R11: The configuration register is at offset 0xD14. Bits 1, 3 and 4 are banked. Bit 8 is stored once and seen by both states. Bit 9 always reads 1. All other bits read 0.
- R12: A permitted write to offset 0xF00 pulses swtrig_valid for one cycle in the next cycle, with swtrig_num=wdata[8:0]. Reads of this offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 1 | Access is privileged |
| req_secure | input | 1 | Access is secure |
| fault_set | input | 32 | Fault bits to set this cycle |
| fault_set_secure | input | 1 | fault_set targets the secure copy |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Bus error response |
| rsp_rdata | output | 32 | Read data |
| sys_reset_req | output | 1 | One-cycle system reset request |
| swtrig_valid | output | 1 | One-cycle software trigger pulse |
| swtrig_num | output | 9 | Triggered interrupt number |
| prigroup_s | output | 3 | Secure priority group |
| prigroup_ns | output | 3 | Non-secure priority group |

## Verification
The hardest case to reach is a non-secure reset request that is blocked because reset-secure-only is set. Reaching it needs a keyed secure write first, then a non-secure keyed write, then the secure bit cleared again to show that the block was what stopped the request. A similar case is a fault bit that is set and cleared in the same cycle, so the stimulus drives fault_set while a clearing write is in flight. Both the extension-present and extension-absent builds receive the same bus traffic side by side. This shows that the alias window and the secure flag fall back correctly when there is no security.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int DW = 32;
  localparam logic [19:0] MAIN_PAGE  = 20'hE000E;
  localparam logic [19:0] ALIAS_PAGE = 20'hE002E;
  localparam logic [11:0] OFF_RSTCTL = 12'hD0C;
  localparam logic [11:0] OFF_CFG    = 12'hD14;
  localparam logic [11:0] OFF_FLT    = 12'hD28;
  localparam logic [11:0] OFF_SWTRIG = 12'hF00;
  localparam logic [15:0] WR_KEY = 16'h05FA;
  localparam logic [15:0] RD_KEY = 16'hFA05;
  localparam logic [DW-1:0] FLT_IMPL   = 32'h030F_BFBB;
  localparam logic [DW-1:0] FLT_SHARED = 32'h0000_FF00;
  localparam logic [DW-1:0] CFG_BANKED = 32'h0000_001A;
  localparam logic [DW-1:0] CFG_SHARED = 32'h0000_0100;
  localparam logic [DW-1:0] CFG_ONES   = 32'h0000_0200;

  typedef enum logic [2:0] {SEL_NONE, SEL_RSTCTL, SEL_CFG, SEL_FLT, SEL_SWTRIG} reg_sel_e;

  typedef struct packed {
    logic     hit;
    logic     razwi;
    logic     err;
    logic     bank_s;
    reg_sel_e sel;
  } route_t;

  function automatic logic [DW-1:0] w1c(logic [DW-1:0] cur, logic [DW-1:0] clr, logic [DW-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic key_ok(logic [DW-1:0] wd);
    return wd[31:16] == WR_KEY;
  endfunction

  function automatic reg_sel_e decode_off(logic [11:0] off);
    case (off)
      OFF_RSTCTL: return SEL_RSTCTL;
      OFF_CFG:    return SEL_CFG;
      OFF_FLT:    return SEL_FLT;
      OFF_SWTRIG: return SEL_SWTRIG;
      default:    return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/sysctl_route.sv
module sysctl_route
  import sysctl_pkg::*;
#(
  parameter bit HAS_SEC = 1'b1
) (
  input  logic          req_valid,
  input  logic [DW-1:0] req_addr,
  input  logic          req_write,
  input  logic          req_priv,
  input  logic          req_secure,
  input  logic          usm_s,
  input  logic          usm_ns,
  output route_t        route
);
  logic in_main, in_alias, sec_ok, usm;

  assign in_main  = req_addr[31:12] == MAIN_PAGE;
  assign in_alias = req_addr[31:12] == ALIAS_PAGE;
  assign sec_ok   = HAS_SEC && req_secure;

  always_comb begin
    route = '{hit: 1'b0, razwi: 1'b0, err: 1'b0, bank_s: 1'b0, sel: SEL_NONE};
    usm = 1'b0;
    if (req_valid) begin
      if (in_alias && !sec_ok) begin
        route.razwi = 1'b1;
      end else if (!in_main && !in_alias) begin
        route.err = 1'b1;
      end else begin
        route.bank_s = in_main && sec_ok;
        route.sel    = decode_off(req_addr[11:0]);
        usm          = route.bank_s ? usm_s : usm_ns;
        if (!req_priv && !(route.sel == SEL_SWTRIG && req_write && usm))
          route.err = 1'b1;
        else
          route.hit = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sysctl_rstctl.sv
module sysctl_rstctl
  import sysctl_pkg::*;
#(
  parameter bit HAS_SEC = 1'b1,
  parameter int PG_W    = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic            bank_s,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic [PG_W-1:0] prigroup_s,
  output logic [PG_W-1:0] prigroup_ns,
  output logic            reset_fire
);
  logic            reqs, bfh, pris, acc;
  logic [PG_W-1:0] pg_s, pg_ns;

  assign acc        = we && key_ok(wdata);
  assign reset_fire = acc && wdata[2] && (bank_s || !reqs);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_s <= '0; pg_ns <= '0; reqs <= 1'b0; bfh <= 1'b0; pris <= 1'b0;
    end else if (acc) begin
      if (bank_s) pg_s <= wdata[8 +: PG_W];
      else        pg_ns <= wdata[8 +: PG_W];
      if (bank_s && HAS_SEC) begin
        reqs <= wdata[3]; bfh <= wdata[13]; pris <= wdata[14];
      end
    end
  end

  always_comb begin
    rdata = '0;
    rdata[31:16] = RD_KEY;
    rdata[14] = pris;
    rdata[13] = bfh;
    rdata[3]  = reqs;
    rdata[8 +: PG_W] = bank_s ? pg_s : pg_ns;
  end

  assign prigroup_s  = pg_s;
  assign prigroup_ns = pg_ns;
endmodule

// File: rtl/sysctl_fault.sv
module sysctl_fault
  import sysctl_pkg::*;
#(
  parameter bit HAS_SEC = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          bank_s,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] fset,
  input  logic          fset_secure,
  output logic [DW-1:0] rdata
);
  localparam logic [DW-1:0] BMASK = FLT_IMPL & ~FLT_SHARED;
  localparam logic [DW-1:0] SMASK = FLT_IMPL & FLT_SHARED;

  logic [DW-1:0] bnk_ns, bnk_s, shr;
  logic          to_s;

  assign to_s = HAS_SEC && fset_secure;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bnk_ns <= '0; shr <= '0;
    end else begin
      bnk_ns <= w1c(bnk_ns, (we && !bank_s) ? wdata : '0, to_s ? '0 : fset) & BMASK;
      shr    <= w1c(shr, we ? wdata : '0, fset) & SMASK;
    end
  end

  generate
    if (HAS_SEC) begin : g_sec_bank
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bnk_s <= '0;
        else bnk_s <= w1c(bnk_s, (we && bank_s) ? wdata : '0, to_s ? fset : '0) & BMASK;
      end
    end else begin : g_no_sec_bank
      assign bnk_s = '0;
    end
  endgenerate

  assign rdata = (bank_s ? bnk_s : bnk_ns) | shr;
endmodule

// File: rtl/sysctl_bank_gate.sv
module sysctl_bank_gate
  import sysctl_pkg::*;
#(
  parameter bit HAS_SEC = 1'b1,
  parameter int PG_W    = 3,
  parameter int IRQ_W   = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [31:0]      req_addr,
  input  logic [31:0]      req_wdata,
  input  logic             req_write,
  input  logic             req_priv,
  input  logic             req_secure,
  input  logic [31:0]      fault_set,
  input  logic             fault_set_secure,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic [31:0]      rsp_rdata,
  output logic             sys_reset_req,
  output logic             swtrig_valid,
  output logic [IRQ_W-1:0] swtrig_num,
  output logic [PG_W-1:0]  prigroup_s,
  output logic [PG_W-1:0]  prigroup_ns
);
  route_t        rt;
  logic [DW-1:0] cfg_s, cfg_ns, cfg_rdata, rst_rdata, flt_rdata, rd_mux;
  logic          cfg_sh, rst_fire, wr_hit, sw_fire;

  sysctl_route #(.HAS_SEC(HAS_SEC)) u_route (
    .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
    .req_priv(req_priv), .req_secure(req_secure),
    .usm_s(cfg_s[1]), .usm_ns(cfg_ns[1]), .route(rt)
  );

  assign wr_hit  = rt.hit && req_write;
  assign sw_fire = wr_hit && rt.sel == SEL_SWTRIG;

  sysctl_rstctl #(.HAS_SEC(HAS_SEC), .PG_W(PG_W)) u_rstctl (
    .clk(clk), .rst_n(rst_n), .we(wr_hit && rt.sel == SEL_RSTCTL),
    .bank_s(rt.bank_s), .wdata(req_wdata), .rdata(rst_rdata),
    .prigroup_s(prigroup_s), .prigroup_ns(prigroup_ns), .reset_fire(rst_fire)
  );

  sysctl_fault #(.HAS_SEC(HAS_SEC)) u_fault (
    .clk(clk), .rst_n(rst_n), .we(wr_hit && rt.sel == SEL_FLT),
    .bank_s(rt.bank_s), .wdata(req_wdata), .fset(fault_set),
    .fset_secure(fault_set_secure), .rdata(flt_rdata)
  );

  // configuration register: banked bits per state, one shared bit, forced ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_s <= '0; cfg_ns <= '0; cfg_sh <= 1'b0;
    end else if (wr_hit && rt.sel == SEL_CFG) begin
      if (rt.bank_s) cfg_s  <= req_wdata & CFG_BANKED;
      else           cfg_ns <= req_wdata & CFG_BANKED;
      cfg_sh <= |(req_wdata & CFG_SHARED);
    end
  end

  assign cfg_rdata = (rt.bank_s ? cfg_s : cfg_ns) | (cfg_sh ? CFG_SHARED : '0) | CFG_ONES;

  always_comb begin
    case (rt.sel)
      SEL_RSTCTL: rd_mux = rst_rdata;
      SEL_CFG:    rd_mux = cfg_rdata;
      SEL_FLT:    rd_mux = flt_rdata;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0; rsp_err <= 1'b0; rsp_rdata <= '0;
      sys_reset_req <= 1'b0; swtrig_valid <= 1'b0; swtrig_num <= '0;
    end else begin
      rsp_valid     <= req_valid;
      rsp_err       <= rt.err;
      rsp_rdata     <= (rt.hit && !req_write) ? rd_mux : '0;
      sys_reset_req <= rst_fire;
      swtrig_valid  <= sw_fire;
      if (sw_fire) swtrig_num <= req_wdata[IRQ_W-1:0];
    end
  end
endmodule

// File: rtl/sysctl_bank_gate_chk.sv
module sysctl_bank_gate_chk
  import sysctl_pkg::*;
#(
  parameter bit HAS_SEC = 1'b1,
  parameter int PG_W    = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [31:0]     req_addr,
  input logic [31:0]     req_wdata,
  input logic            req_write,
  input logic            req_priv,
  input logic            req_secure,
  input logic            rsp_valid,
  input logic            rsp_err,
  input logic [31:0]     rsp_rdata,
  input logic            sys_reset_req,
  input logic            swtrig_valid,
  input logic [PG_W-1:0] prigroup_s,
  input logic            rst_fire
);
  assert_rsp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_err_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_valid && rsp_rdata == '0));
  assert_unpriv_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_priv && req_addr[31:12] == MAIN_PAGE &&
     !(req_write && req_addr[11:0] == OFF_SWTRIG)) |=> rsp_err);
  assert_alias_razwi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[31:12] == ALIAS_PAGE && !(HAS_SEC && req_secure))
    |=> (!rsp_err && rsp_rdata == '0));
  assert_nosec_pg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !HAS_SEC |-> prigroup_s == '0);
  assert_reset_keyed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req |-> $past(req_valid && req_write && req_wdata[31:16] == WR_KEY && req_wdata[2]));
  assert_reset_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_fire |=> sys_reset_req);
  assert_cfg_ones_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_priv && !req_write && req_addr[31:12] == MAIN_PAGE &&
     req_addr[11:0] == OFF_CFG) |=> rsp_rdata[9]);
  assert_trig_written_R12: assert property (@(posedge clk) disable iff (!rst_n)
    swtrig_valid |-> $past(req_valid && req_write && req_addr[11:0] == OFF_SWTRIG));
endmodule

bind sysctl_bank_gate sysctl_bank_gate_chk #(.HAS_SEC(HAS_SEC), .PG_W(PG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .req_wdata(req_wdata), .req_write(req_write), .req_priv(req_priv),
  .req_secure(req_secure), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
  .rsp_rdata(rsp_rdata), .sys_reset_req(sys_reset_req),
  .swtrig_valid(swtrig_valid), .prigroup_s(prigroup_s), .rst_fire(rst_fire)
);

// File: tb/test_sysctl_bank_gate.sv
module test_sysctl_bank_gate;
  localparam int CLK_P = 10;
  localparam logic [31:0] M = 32'hE000E000;
  localparam logic [31:0] A = 32'hE002E000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic i_valid = 0, i_write = 0, i_priv = 0, i_sec = 0, i_fsec = 0;
  logic [31:0] i_addr = 0, i_wdata = 0, i_fset = 0;
  int checks = 0, fails = 0;
  bit done = 0;
  string cur_tag = "R1";

  always #(CLK_P/2) clk = ~clk;

  logic o_valid[2], o_err[2], o_rst[2], o_sw[2];
  logic [31:0] o_rdata[2];
  logic [8:0] o_swnum[2];
  logic [2:0] o_pgs[2], o_pgns[2];

  wire w0_v, w0_e, w0_r, w0_s, w1_v, w1_e, w1_r, w1_s;
  wire [31:0] w0_d, w1_d;
  wire [8:0] w0_n, w1_n;
  wire [2:0] w0_ps, w0_pn, w1_ps, w1_pn;

  sysctl_bank_gate #(.HAS_SEC(1'b1)) i_sysctl_bank_gate (
    .clk(clk), .rst_n(rst_n), .req_valid(i_valid), .req_addr(i_addr),
    .req_wdata(i_wdata), .req_write(i_write), .req_priv(i_priv), .req_secure(i_sec),
    .fault_set(i_fset), .fault_set_secure(i_fsec), .rsp_valid(w0_v), .rsp_err(w0_e),
    .rsp_rdata(w0_d), .sys_reset_req(w0_r), .swtrig_valid(w0_s), .swtrig_num(w0_n),
    .prigroup_s(w0_ps), .prigroup_ns(w0_pn));

  sysctl_bank_gate #(.HAS_SEC(1'b0)) i_sysctl_bank_gate_nosec (
    .clk(clk), .rst_n(rst_n), .req_valid(i_valid), .req_addr(i_addr),
    .req_wdata(i_wdata), .req_write(i_write), .req_priv(i_priv), .req_secure(i_sec),
    .fault_set(i_fset), .fault_set_secure(i_fsec), .rsp_valid(w1_v), .rsp_err(w1_e),
    .rsp_rdata(w1_d), .sys_reset_req(w1_r), .swtrig_valid(w1_s), .swtrig_num(w1_n),
    .prigroup_s(w1_ps), .prigroup_ns(w1_pn));

  always_comb begin
    o_valid[0] = w0_v; o_err[0] = w0_e; o_rdata[0] = w0_d; o_rst[0] = w0_r;
    o_sw[0] = w0_s; o_swnum[0] = w0_n; o_pgs[0] = w0_ps; o_pgns[0] = w0_pn;
    o_valid[1] = w1_v; o_err[1] = w1_e; o_rdata[1] = w1_d; o_rst[1] = w1_r;
    o_sw[1] = w1_s; o_swnum[1] = w1_n; o_pgs[1] = w1_ps; o_pgns[1] = w1_pn;
  end

  // behavioural reference state, index 0 = extension present, 1 = absent
  bit has_sec[2] = '{1'b1, 1'b0};
  logic [2:0]  m_pg[2][2];
  logic        m_reqs[2], m_bfh[2], m_pris[2], m_cfgsh[2];
  logic [31:0] m_flt[2][2], m_cfg[2][2];
  logic [7:0]  m_fsh[2];
  logic        e_valid[2], e_err[2], e_rst[2], e_sw[2];
  logic [31:0] e_rdata[2];
  logic [8:0]  e_swnum[2];
  logic [2:0]  e_pgs[2], e_pgns[2];

  initial begin
    for (int k = 0; k < 2; k++) begin
      m_pg[k][0] = 0; m_pg[k][1] = 0; m_reqs[k] = 0; m_bfh[k] = 0; m_pris[k] = 0;
      m_cfgsh[k] = 0; m_flt[k][0] = 0; m_flt[k][1] = 0; m_cfg[k][0] = 0; m_cfg[k][1] = 0;
      m_fsh[k] = 0; e_valid[k] = 0; e_err[k] = 0; e_rst[k] = 0; e_sw[k] = 0;
      e_rdata[k] = 0; e_swnum[k] = 0; e_pgs[k] = 0; e_pgns[k] = 0;
    end
  end

  task automatic model(int k);
    bit sec_ok, bs, err, razwi, hit, keyed;
    logic [11:0] off;
    logic [31:0] rd, clr;
    sec_ok = has_sec[k] && i_sec;
    bs = 0; err = 0; razwi = 0; hit = 0; rd = 0; off = i_addr[11:0];
    e_valid[k] = i_valid; e_rst[k] = 0; e_sw[k] = 0;
    if (i_valid) begin
      if (i_addr[31:12] == A[31:12]) razwi = !sec_ok;
      else if (i_addr[31:12] == M[31:12]) bs = sec_ok;
      else err = 1;
      if (!razwi && !err) begin
        if (!i_priv && !(i_write && off == 12'hF00 && m_cfg[k][bs][1])) err = 1;
        else hit = 1;
      end
    end
    if (hit && !i_write) begin
      if (off == 12'hD0C)
        rd = {16'hFA05, 1'b0, m_pris[k], m_bfh[k], 2'b00, m_pg[k][bs], 4'h0, m_reqs[k], 3'b000};
      else if (off == 12'hD14)
        rd = m_cfg[k][bs] | {23'd0, m_cfgsh[k], 8'd0} | 32'h200;
      else if (off == 12'hD28)
        rd = m_flt[k][bs] | {16'd0, m_fsh[k], 8'd0};
    end
    e_err[k] = err; e_rdata[k] = rd;
    for (int b = 0; b < 2; b++) begin
      clr = (hit && i_write && off == 12'hD28 && b == int'(bs)) ? i_wdata : 32'd0;
      m_flt[k][b] = ((m_flt[k][b] & ~clr) |
                     ((b == int'(has_sec[k] && i_fsec)) ? i_fset : 32'd0)) & 32'h030F00BB;
    end
    m_fsh[k] = ((m_fsh[k] & ~((hit && i_write && off == 12'hD28) ? i_wdata[15:8] : 8'd0))
                | i_fset[15:8]) & 8'hBF;
    keyed = hit && i_write && off == 12'hD0C && i_wdata[31:16] == 16'h05FA;
    if (keyed) begin
      e_rst[k] = i_wdata[2] && (bs || !m_reqs[k]);
      m_pg[k][bs] = i_wdata[10:8];
      if (bs) begin
        m_reqs[k] = i_wdata[3]; m_bfh[k] = i_wdata[13]; m_pris[k] = i_wdata[14];
      end
    end
    if (hit && i_write && off == 12'hD14) begin
      m_cfg[k][bs] = i_wdata & 32'h1A; m_cfgsh[k] = i_wdata[8];
    end
    if (hit && i_write && off == 12'hF00) begin
      e_sw[k] = 1; e_swnum[k] = i_wdata[8:0];
    end
    e_pgs[k] = m_pg[k][1]; e_pgns[k] = m_pg[k][0];
  endtask

  // compare every clock, a quarter period after the edge
  always @(posedge clk) begin
    #(CLK_P/4);
    if (!done) begin
      for (int k = 0; k < 2; k++) begin
        checks++;
        if (o_valid[k] !== e_valid[k] || o_err[k] !== e_err[k] || o_rdata[k] !== e_rdata[k] ||
            o_rst[k] !== e_rst[k] || o_sw[k] !== e_sw[k] || (e_sw[k] && o_swnum[k] !== e_swnum[k]) ||
            o_pgs[k] !== e_pgs[k] || o_pgns[k] !== e_pgns[k]) begin
          fails++;
          $display("FAIL %s inst%0d actual v=%b e=%b d=%h rst=%b sw=%b n=%h pg=%h/%h expected v=%b e=%b d=%h rst=%b sw=%b n=%h pg=%h/%h",
            cur_tag, k, o_valid[k], o_err[k], o_rdata[k], o_rst[k], o_sw[k], o_swnum[k], o_pgs[k], o_pgns[k],
            e_valid[k], e_err[k], e_rdata[k], e_rst[k], e_sw[k], e_swnum[k], e_pgs[k], e_pgns[k]);
        end
      end
    end
  end

  task automatic cyc(string tag, bit v, logic [31:0] a, logic [31:0] wd, bit w, bit p, bit s,
                     logic [31:0] fs = 0, bit fsec = 0);
    @(negedge clk);
    cur_tag = tag; i_valid = v; i_addr = a; i_wdata = wd; i_write = w; i_priv = p;
    i_sec = s; i_fset = fs; i_fsec = fsec;
    model(0); model(1);
  endtask
  task automatic rd(string tag, logic [31:0] a, bit p, bit s); cyc(tag, 1, a, 0, 0, p, s); endtask
  task automatic wr(string tag, logic [31:0] a, logic [31:0] wd, bit p, bit s); cyc(tag, 1, a, wd, 1, p, s); endtask
  task automatic idle(string tag); cyc(tag, 0, 0, 0, 0, 0, 0); endtask

  initial begin
    repeat (3) idle("R1");
    rst_n = 1'b1;
    idle("R1");
    // R5 key, banking of priority group
    rd("R5", M + 12'hD0C, 1, 0);
    wr("R5", M + 12'hD0C, 32'h1234_0500, 1, 0);
    wr("R5", M + 12'hD0C, 32'h05FA_0500, 1, 0);
    wr("R5", M + 12'hD0C, 32'h05FA_0300, 1, 1);
    rd("R5", M + 12'hD0C, 1, 0);
    rd("R5", M + 12'hD0C, 1, 1);
    // R3 alias reaches non-secure copy for secure access
    wr("R3", A + 12'hD0C, 32'h05FA_0600, 1, 1);
    rd("R3", A + 12'hD0C, 1, 1);
    // R4 alias from non-secure
    wr("R4", A + 12'hD0C, 32'h05FA_0100, 1, 0);
    rd("R4", A + 12'hD0C, 1, 0);
    rd("R4", M + 12'h100, 1, 0);
    // R6 secure-only bits
    wr("R6", M + 12'hD0C, 32'h05FA_6608, 1, 0);
    rd("R6", M + 12'hD0C, 1, 0);
    wr("R6", M + 12'hD0C, 32'h05FA_6308, 1, 1);
    rd("R6", M + 12'hD0C, 1, 0);
    // R7 reset gating (bit 3 now set in secure build)
    wr("R7", M + 12'hD0C, 32'h05FA_0604, 1, 0);
    idle("R7");
    wr("R7", M + 12'hD0C, 32'h05FA_030C, 1, 1);
    idle("R7");
    wr("R7", M + 12'hD0C, 32'h05FA_0300, 1, 1);
    wr("R7", M + 12'hD0C, 32'h05FA_0604, 1, 0);
    wr("R7", M + 12'hD0C, 32'h0000_0004, 1, 1);
    // R8 debug-only bits
    wr("R8", M + 12'hD0C, 32'h05FA_0203, 1, 0);
    rd("R8", M + 12'hD0C, 1, 0);
    // R9 fault set, read, clear, set-wins
    cyc("R9", 0, 0, 0, 0, 0, 0, 32'hFFFF_FFFF, 1);
    rd("R9", M + 12'hD28, 1, 1);
    rd("R9", M + 12'hD28, 1, 0);
    cyc("R9", 0, 0, 0, 0, 0, 0, 32'h0001_0002, 0);
    wr("R9", M + 12'hD28, 32'h0000_0003, 1, 1);
    rd("R9", M + 12'hD28, 1, 1);
    cyc("R9", 1, M + 12'hD28, 32'h0001_0000, 1, 1, 0, 32'h0001_0000, 0);
    rd("R9", M + 12'hD28, 1, 0);
    // R10 shared byte cleared from non-secure
    wr("R10", M + 12'hD28, 32'h0000_0F00, 1, 0);
    rd("R10", M + 12'hD28, 1, 1);
    rd("R10", M + 12'hD28, 1, 0);
    // R11 configuration banking
    wr("R11", M + 12'hD14, 32'hFFFF_FFFF, 1, 0);
    rd("R11", M + 12'hD14, 1, 1);
    rd("R11", M + 12'hD14, 1, 0);
    wr("R11", M + 12'hD14, 32'h0000_0000, 1, 1);
    rd("R11", M + 12'hD14, 1, 0);
    // R2 privilege rules
    rd("R2", M + 12'hD0C, 0, 0);
    wr("R2", M + 12'hF00, 32'h0000_0011, 0, 1);
    wr("R2", M + 12'hF00, 32'h0000_0022, 0, 0);
    rd("R2", M + 12'hF00, 0, 0);
    rd("R2", 32'h4000_0000, 1, 1);
    wr("R2", M + 12'hD14, 32'h0000_0000, 1, 0);
    wr("R2", M + 12'hF00, 32'h0000_0033, 0, 0);
    // R12 trigger pulses, back to back
    wr("R12", M + 12'hF00, 32'hFFFF_F1A5, 1, 1);
    wr("R12", A + 12'hF00, 32'h0000_0007, 1, 1);
    rd("R12", M + 12'hF00, 1, 0);
    idle("R12");
    idle("R1");
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule